// File: doc/BRIEF.md
# Direct-Mapped Line Cache with Wide Refill

This block sits between a processor's word-wide load/store port and a main memory whose read path is one full line (four words) wide. It holds 4096 lines of four 32-bit words, 64 KB of data in all. Each line has a tag and a valid flag. A 32-bit byte address is split, from the low end up, into a 2-bit byte offset, a 2-bit word select, a 12-bit line index and a 16-bit tag. A read that finds its line returns the selected word on the next cycle and does not stall.

A read that misses sends one line request to memory. The block waits for the whole 128-bit line, writes it into the array, and then hands the requested word to the processor. Stores are written through to memory. A store that finds its line updates the array at once and sends a one-word write, with byte enables, to memory. A store that misses first refills the line, merges the store into it, and then sends the write. The processor sees a stall flag for the whole of any memory transaction. Only one request is in flight at a time: a new request is taken only while the controller is idle.

With a memory that needs one address cycle, 14 access cycles and one transfer cycle, a read miss or a store costs 16 stall cycles. A store miss costs 32.

Top module: `dm_line_cache`

## Requirements
- R1: Reset clears every valid flag and leaves `cpuStall`, `cpuDone` and `memReq` low. The first read of any line after reset is a miss.
- R2: A read request taken while idle that hits raises `cpuDone` in the next cycle with the stored word. `cpuStall` stays low and no memory request is made.
- R3: A read miss issues one request with `memWe`=0 and `memAddr` equal to the request address with bits [3:0] cleared. `cpuStall` is high from the cycle after the request until the cycle in which `cpuDone` rises with the fetched word. With the 1+14+1 memory this is 16 stall cycles, and `cpuDone` comes 17 cycles after the request edge.
- R4: A hit needs the valid flag set and the stored tag (address bits [31:16]) equal to the request tag. A request whose index (bits [15:4]) matches but whose tag differs misses and replaces the line.
- R5: Address bits [3:2] select the word within the line: 0 selects line bits [31:0], and so on up to 3, which selects bits [127:96].
- R6: A store that hits merges `cpuWData` into the cached word; byte enable bit i covers data bits 8i+7:8i. It issues one memory write with `memWe`=1, `memAddr` equal to the request address, and `memWData`/`memBe` equal to the request. `cpuDone` rises in the cycle after `memValid`.
- R7: A store that misses first performs a line read, then installs the line with the store merged into it, then issues the write of R6. This makes two memory requests, and a later read of that line hits.
- R8: A request raised while the controller is busy is ignored. It makes no memory request and changes no cache state, and it is not taken later unless it is raised again while idle.
- R9: `memReq` is a one-cycle pulse per transaction, and it is only high while `cpuStall` is high.
- R10: Byte-offset bits [1:0] do not affect which word a read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, taken when idle |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address |
| cpuWData | input | 32 | Store data |
| cpuBe | input | 4 | Store byte enables |
| cpuRData | output | 32 | Load data, valid with cpuDone |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuStall | output | 1 | Controller busy with memory |
| memReq | output | 1 | Memory request pulse |
| memWe | output | 1 | 1 = word write, 0 = line read |
| memAddr | output | 32 | Memory byte address |
| memWData | output | 32 | Write-through data |
| memBe | output | 4 | Write-through byte enables |
| memRData | input | 128 | Refill line from memory |
| memValid | input | 1 | Memory completion (line valid or write accepted) |

## Verification
The lookup is exercised with a fixed sequence of accesses:
- a cold read followed by reads of all four words of the same line, which separates the word select from the refill path;
- a read with a non-zero byte offset, which checks that those bits are ignored;
- two tags that alias to the same index, which show that the tag is compared and that the line is replaced;
- full and partial byte-enable stores, which separate the merge from a plain overwrite;
- a store to an absent line, which separates allocate-then-write from write-around;
- the all-ones address, which tests the top index and tag;
- requests raised while busy, which check that they are ignored;
- a reset in mid-run, which checks that all lines are invalidated.

The expected read data come from the bench's own memory model. The memory write fields and the number of stall cycles are checked against the 1+14+1 timing.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WRTH = 2'd2
  } cacheState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic latchReq;     // capture the live request
    logic writeHit;     // merge store into the looked-up line
    logic install;      // write refilled line, tag and valid
    logic issueFill;    // start a line read
    logic issueWrite;   // start a word write-through
    logic respond;      // pulse cpuDone
    logic loadRdLookup; // return word from the array
    logic loadRdMem;    // return word from the refill line
  } ctrlStrobes_t;

endpackage

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuReq,
  input  logic         curWe,
  input  logic         lookupHit,
  input  logic         memValid,
  output ctrlStrobes_t strb,
  output logic         isIdle,
  output logic         cpuStall
);

  cacheState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (lookupHit) begin
            if (curWe) begin
              strb.latchReq   = 1'b1;
              strb.writeHit   = 1'b1;
              strb.issueWrite = 1'b1;
              nextState       = ST_WRTH;
            end else begin
              strb.respond      = 1'b1;
              strb.loadRdLookup = 1'b1;
            end
          end else begin
            strb.latchReq  = 1'b1;
            strb.issueFill = 1'b1;
            nextState      = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (memValid) begin
          strb.install = 1'b1;
          if (curWe) begin
            strb.issueWrite = 1'b1;
            nextState       = ST_WRTH;
          end else begin
            strb.respond   = 1'b1;
            strb.loadRdMem = 1'b1;
            nextState      = ST_IDLE;
          end
        end
      end
      ST_WRTH: begin
        if (memValid) begin
          strb.respond = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign isIdle   = (state == ST_IDLE);
  assign cpuStall = (state != ST_IDLE);

endmodule

// File: rtl/dm_cache_dpath.sv
module dm_cache_dpath
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int INDEX_W = 12,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int BE_W   = WORD_W / 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              isIdle,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  input  logic [BE_W-1:0]   cpuBe,
  input  logic [LINE_W-1:0] memRData,
  output logic              curWe,
  output logic              lookupHit,
  output logic [WORD_W-1:0] cpuRData,
  output logic              cpuDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic [BE_W-1:0]   memBe
);

  localparam int OFF_W  = $clog2(BE_W);
  localparam int SEL_W  = $clog2(WORDS);
  localparam int LOW_W  = OFF_W + SEL_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - LOW_W;
  localparam int LINES  = 1 << INDEX_W;

  // Storage
  logic [LINE_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validVec;

  // Held request for multi-cycle transactions
  logic              reqWe;
  logic [ADDR_W-1:0] reqAddr;
  logic [WORD_W-1:0] reqWData;
  logic [BE_W-1:0]   reqBe;

  logic [ADDR_W-1:0] curAddr;
  logic [WORD_W-1:0] curWData;
  logic [BE_W-1:0]   curBe;

  assign curWe    = isIdle ? cpuWe    : reqWe;
  assign curAddr  = isIdle ? cpuAddr  : reqAddr;
  assign curWData = isIdle ? cpuWData : reqWData;
  assign curBe    = isIdle ? cpuBe    : reqBe;

  logic [INDEX_W-1:0] curIdx;
  logic [TAG_W-1:0]   curTag;
  logic [SEL_W-1:0]   curSel;

  assign curIdx = curAddr[LOW_W +: INDEX_W];
  assign curTag = curAddr[ADDR_W-1 -: TAG_W];
  assign curSel = curAddr[OFF_W +: SEL_W];

  logic [LINE_W-1:0] lookupLine;
  assign lookupLine = dataArr[curIdx];
  assign lookupHit  = validVec[curIdx] && (tagArr[curIdx] == curTag);

  // Word multiplexers on the array line and on the refill line
  logic [WORD_W-1:0] lookupWords [WORDS];
  logic [WORD_W-1:0] memWords    [WORDS];
  logic [WORD_W-1:0] lookupWord, memWord;

  // Store merge into a line: base is the refill line during install
  logic [LINE_W-1:0] mergeBase, mergedLine;
  assign mergeBase = strb.install ? memRData : lookupLine;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign lookupWords[w] = lookupLine[w*WORD_W +: WORD_W];
    assign memWords[w]    = memRData[w*WORD_W +: WORD_W];
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign mergedLine[w*WORD_W + 8*b +: 8] =
        (curSel == SEL_W'(w) && curBe[b]) ? curWData[8*b +: 8]
                                          : mergeBase[w*WORD_W + 8*b +: 8];
    end
  end

  assign lookupWord = lookupWords[curSel];
  assign memWord    = memWords[curSel];

  // Array writes (no reset on data and tags)
  always_ff @(posedge clk) begin
    if (strb.writeHit) begin
      dataArr[curIdx] <= mergedLine;
    end else if (strb.install) begin
      dataArr[curIdx] <= curWe ? mergedLine : memRData;
      tagArr[curIdx]  <= curTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             validVec         <= '0;
    else if (strb.install) validVec[curIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWe    <= 1'b0;
      reqAddr  <= '0;
      reqWData <= '0;
      reqBe    <= '0;
    end else if (strb.latchReq) begin
      reqWe    <= cpuWe;
      reqAddr  <= cpuAddr;
      reqWData <= cpuWData;
      reqBe    <= cpuBe;
    end
  end

  // Processor response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuDone  <= 1'b0;
      cpuRData <= '0;
    end else begin
      cpuDone <= strb.respond;
      if (strb.loadRdLookup)   cpuRData <= lookupWord;
      else if (strb.loadRdMem) cpuRData <= memWord;
    end
  end

  // Memory request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memWData <= '0;
      memBe    <= '0;
    end else begin
      memReq <= strb.issueFill | strb.issueWrite;
      if (strb.issueFill) begin
        memWe   <= 1'b0;
        memAddr <= {curAddr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
      end else if (strb.issueWrite) begin
        memWe    <= 1'b1;
        memAddr  <= curAddr;
        memWData <= curWData;
        memBe    <= curBe;
      end
    end
  end

endmodule

// File: rtl/dm_line_cache.sv
module dm_line_cache
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int INDEX_W = 12,
  localparam int LINE_W = WORD_W * WORDS,
  localparam int BE_W   = WORD_W / 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  input  logic [BE_W-1:0]   cpuBe,
  output logic [WORD_W-1:0] cpuRData,
  output logic              cpuDone,
  output logic              cpuStall,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic [BE_W-1:0]   memBe,
  input  logic [LINE_W-1:0] memRData,
  input  logic              memValid
);

  ctrlStrobes_t strb;
  logic         isIdle, curWe, lookupHit;

  dm_cache_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .curWe     (curWe),
    .lookupHit (lookupHit),
    .memValid  (memValid),
    .strb      (strb),
    .isIdle    (isIdle),
    .cpuStall  (cpuStall)
  );

  dm_cache_dpath #(
    .ADDR_W  (ADDR_W),
    .WORD_W  (WORD_W),
    .WORDS   (WORDS),
    .INDEX_W (INDEX_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .isIdle    (isIdle),
    .cpuWe     (cpuWe),
    .cpuAddr   (cpuAddr),
    .cpuWData  (cpuWData),
    .cpuBe     (cpuBe),
    .memRData  (memRData),
    .curWe     (curWe),
    .lookupHit (lookupHit),
    .cpuRData  (cpuRData),
    .cpuDone   (cpuDone),
    .memReq    (memReq),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .memBe     (memBe)
  );

endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              cpuDone,
  input logic              cpuStall,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid
);

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);                                   // R9

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> cpuStall);                                  // R9

  AST_STALL_START_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuStall) |-> memReq);                           // R2

  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr[3:0] == 4'd0));        // R3

  AST_DONE_NOT_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !cpuStall);                                // R3

  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && !memValid) |=> !cpuDone);                 // R8

endmodule

bind dm_line_cache dm_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuDone  (cpuDone),
  .cpuStall (cpuStall),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memValid (memValid)
);

// File: tb/dm_line_cache_tb.sv
module dm_line_cache_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0]  cpuAddr = '0, cpuWData = '0;
  logic [3:0]   cpuBe = '0;
  logic [31:0]  cpuRData;
  logic         cpuDone, cpuStall;
  logic         memReq, memWe;
  logic [31:0]  memAddr, memWData;
  logic [3:0]   memBe;
  logic [127:0] memRData = '0;
  logic         memValid = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  dm_line_cache dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuBe(cpuBe), .cpuRData(cpuRData), .cpuDone(cpuDone),
    .cpuStall(cpuStall), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memBe(memBe), .memRData(memRData), .memValid(memValid)
  );

  // ---------------- memory model: 1 address + 14 access + 1 transfer
  logic [31:0] memStore [logic [29:0]];
  int          reqCount = 0, wrCount = 0;
  logic [31:0] lastWrAddr = '0, lastWrData = '0;
  logic [3:0]  lastWrBe = '0;
  logic [29:0] pendLine = '0;
  int          latCnt = 0;

  function automatic logic [31:0] patWord(logic [29:0] wi);
    return ({2'b0, wi} * 32'h0100_0193) ^ 32'h9E37_79B9;
  endfunction

  function automatic logic [31:0] modelWord(logic [29:0] wi);
    if (memStore.exists(wi)) return memStore[wi];
    return patWord(wi);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      latCnt   <= 0;
      memValid <= 1'b0;
    end else begin
      if (memReq) begin
        reqCount <= reqCount + 1;
        latCnt   <= 1;
        pendLine <= memAddr[31:2] & ~30'd3;
        if (memWe) begin
          logic [31:0] w;
          w = modelWord(memAddr[31:2]);
          for (int b = 0; b < 4; b++) if (memBe[b]) w[8*b +: 8] = memWData[8*b +: 8];
          memStore[memAddr[31:2]] = w;
          wrCount    <= wrCount + 1;
          lastWrAddr <= memAddr;
          lastWrData <= memWData;
          lastWrBe   <= memBe;
        end
      end else if (latCnt == 15) latCnt <= 0;
      else if (latCnt != 0)      latCnt <= latCnt + 1;
      memValid <= (latCnt == 14);
      if (latCnt == 14)
        for (int w = 0; w < 4; w++) memRData[32*w +: 32] <= modelWord(pendLine | 30'(w));
    end
  end

  // ---------------- bookkeeping
  int total = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd,
                        output int cyc, output int stl);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWData = wd; cpuBe = be;
    @(negedge clk);
    cpuReq = 1'b0;
    cyc = 1; stl = 0;
    while (!cpuDone && cyc < 200) begin
      if (cpuStall) stl++;
      @(negedge clk);
      cyc++;
    end
    rd = cpuRData;
  endtask

  // ---------------- stimulus table: we, addr, wdata, be, expected cycles, expected memReq count
  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [7:0]  cyc;
    logic [3:0]  reqs;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1234, 32'h0,         4'h0, 8'd17, 4'd1}, // cold read miss
    '{1'b0, 32'h0000_1238, 32'h0,         4'h0, 8'd1,  4'd0}, // word 2
    '{1'b0, 32'h0000_1230, 32'h0,         4'h0, 8'd1,  4'd0}, // word 0
    '{1'b0, 32'h0000_123C, 32'h0,         4'h0, 8'd1,  4'd0}, // word 3
    '{1'b0, 32'h0000_1236, 32'h0,         4'h0, 8'd1,  4'd0}, // byte offset 2
    '{1'b0, 32'h0001_1234, 32'h0,         4'h0, 8'd17, 4'd1}, // alias tag
    '{1'b0, 32'h0000_1234, 32'h0,         4'h0, 8'd17, 4'd1}, // evicted
    '{1'b1, 32'h0000_1238, 32'hDEAD_BEEF, 4'hF, 8'd17, 4'd1}, // write hit full
    '{1'b0, 32'h0000_1238, 32'h0,         4'h0, 8'd1,  4'd0},
    '{1'b1, 32'h0000_123C, 32'h1122_3344, 4'h5, 8'd17, 4'd1}, // write hit partial
    '{1'b0, 32'h0000_123C, 32'h0,         4'h0, 8'd1,  4'd0},
    '{1'b1, 32'h0002_5550, 32'hCAFE_F00D, 4'hF, 8'd33, 4'd2}, // write miss
    '{1'b0, 32'h0002_5554, 32'h0,         4'h0, 8'd1,  4'd0},
    '{1'b0, 32'h0002_5550, 32'h0,         4'h0, 8'd1,  4'd0},
    '{1'b0, 32'hFFFF_FFFC, 32'h0,         4'h0, 8'd17, 4'd1}, // top index and tag
    '{1'b0, 32'hFFFF_FFF0, 32'h0,         4'h0, 8'd1,  4'd0}
  };

  function automatic string tagOf(int i);
    case (i)
      0, 14:        return "R3 R1";
      1, 2, 3, 15:  return "R2 R5";
      4:            return "R10";
      5, 6:         return "R4";
      7, 8, 9, 10:  return "R6";
      default:      return "R7";
    endcase
  endfunction

  // ---------------- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] rd, expW;
    int cyc, stl, r0, w0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!cpuStall && !cpuDone && !memReq, "R1 reset outputs idle",
          {29'b0, cpuStall, cpuDone, memReq}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v    = VECS[i];
      expW = modelWord(v.addr[31:2]);
      r0   = reqCount;
      access(v.we, v.addr, v.wd, v.be, rd, cyc, stl);
      check(cyc == int'(v.cyc), {tagOf(i), " latency"}, 32'(cyc), 32'(v.cyc));
      check((reqCount - r0) == int'(v.reqs), {tagOf(i), " memory requests"},
            32'(reqCount - r0), 32'(v.reqs));
      if (v.cyc == 8'd17 && !v.we)
        check(stl == 16, {tagOf(i), " stall cycles"}, 32'(stl), 32'd16);
      if (!v.we)
        check(rd == expW, {tagOf(i), " read data"}, rd, expW);
      else
        check(lastWrAddr == v.addr && lastWrData == v.wd && lastWrBe == v.be,
              {tagOf(i), " write-through fields"}, lastWrData, v.wd);
    end

    // R6 partial merge: bytes 0 and 2 from the store, 1 and 3 from the line
    expW = (patWord(30'h48F) & 32'hFF00_FF00) | (32'h1122_3344 & 32'h00FF_00FF);
    access(1'b0, 32'h0000_123C, 32'h0, 4'h0, rd, cyc, stl);
    check(rd == expW && cyc == 1, "R6 byte-enable merge", rd, expW);

    // R8: requests while busy are ignored
    r0 = reqCount; w0 = wrCount;
    expW = modelWord(30'h0003_0100 >> 2);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 32'h0003_0100;
    @(negedge clk);
    cpuWe = 1'b1; cpuAddr = 32'h0000_0100; cpuWData = 32'h5555_AAAA; cpuBe = 4'hF;
    repeat (8) @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
    cyc = 0;
    while (!cpuDone && cyc < 100) begin @(negedge clk); cyc++; end
    check(cpuRData == expW, "R8 data of taken request", cpuRData, expW);
    check(reqCount - r0 == 1 && wrCount == w0, "R8 busy request made no transfer",
          32'(reqCount - r0), 32'd1);
    repeat (3) @(negedge clk);
    check(!cpuStall && reqCount - r0 == 1, "R8 dropped request not taken later",
          32'(reqCount - r0), 32'd1);
    access(1'b0, 32'h0000_0100, 32'h0, 4'h0, rd, cyc, stl);
    check(cyc == 17, "R8 R4 busy store left index untouched", 32'(cyc), 32'd17);
    check(rd == modelWord(30'h40), "R8 value unchanged in memory", rd, modelWord(30'h40));

    // R1: reset in mid-run invalidates lines
    access(1'b0, 32'h0000_1238, 32'h0, 4'h0, rd, cyc, stl);
    check(cyc == 1, "R1 line present before reset", 32'(cyc), 32'd1);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(!cpuStall && !cpuDone && !memReq, "R1 outputs after reset",
          {29'b0, cpuStall, cpuDone, memReq}, 32'h0);
    access(1'b0, 32'h0000_1238, 32'h0, 4'h0, rd, cyc, stl);
    check(cyc == 17, "R1 miss after reset", 32'(cyc), 32'd17);
    check(rd == 32'hDEAD_BEEF, "R1 R3 refetch returns stored word", rd, 32'hDEAD_BEEF);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule